// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the purely combinational datapath of an accumulator-oriented microcontroller core. It takes a 4-bit operation code, the current accumulator byte, a second operand byte and the incoming carry, half-carry and overflow flags. In the same cycle it returns the new accumulator byte and the new flag values. The surrounding core fetches the operands, then writes the result back into the accumulator and the flags into its status register. The block holds no state.

The operation set covers binary add with and without carry, subtract with borrow, increment and decrement, bitwise AND/OR/XOR, clear and complement, exchange of the two nibbles, rotates left and right either inside the byte or through the carry, and a decimal-adjust step that corrects a packed-BCD sum. Each operation produces all three flags. An operation that does not define a flag passes the incoming flag value through unchanged, so the caller can write all three flags on every operation.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) gives res_o = (acc_i + opnd_i) mod 256 and ignores cy_i. cy_o is the carry out of bit 7 and ac_o is the carry out of bit 3. ov_o is the carry into bit 7 XOR the carry out of bit 7.
- R2: Op 1 (add with carry) works like R1, except that cy_i is added as a third term. The flags follow the same rules as R1.
- R3: Op 2 (subtract with borrow) gives res_o = (acc_i - opnd_i - cy_i) mod 256. cy_o is the borrow out of bit 7 and ac_o is the borrow out of bit 3. ov_o is the borrow into bit 7 XOR the borrow out of bit 7.
- R4: Op 3 (increment) and op 4 (decrement) change acc_i by one and wrap around at 8 bits. All three flags pass through unchanged.
- R5: Op 5 (AND), op 6 (OR) and op 7 (XOR) combine acc_i and opnd_i bit by bit. All flags pass through unchanged.
- R6: Op 8 (clear) gives 0x00. Op 9 (complement) gives ~acc_i. All flags pass through unchanged for both.
- R7: Op 10 (nibble swap) gives {acc_i[3:0], acc_i[7:4]}. All flags pass through unchanged.
- R8: Op 11 (rotate left) gives {acc_i[6:0], acc_i[7]}. Op 13 (rotate right) gives {acc_i[0], acc_i[7:1]}. All flags pass through unchanged for both.
- R9: Op 12 (rotate left through carry) gives {acc_i[6:0], cy_i} with cy_o = acc_i[7]. Op 14 (rotate right through carry) gives {cy_i, acc_i[7:1]} with cy_o = acc_i[0]. ac_o and ov_o pass through unchanged.
- R10: Op 15 (decimal adjust) works in two steps.
  - First, 0x06 is added if the low nibble is above 9 or ac_i is set.
  - Second, 0x60 is added if the resulting high nibble is above 9, or if cy_i is set, or if the first step carried out of bit 7.
  - cy_o is set when either step carries out of bit 7, or when cy_i is set. This step never clears the carry. ac_o and ov_o pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code, encoded as listed in the requirements |
| acc_i | input | 8 | Accumulator value (first operand) |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Incoming carry / borrow flag |
| ac_i | input | 1 | Incoming half-carry flag |
| ov_i | input | 1 | Incoming overflow flag |
| res_o | output | 8 | Result for the accumulator |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New half-carry flag |
| ov_o | output | 1 | New overflow flag |

## Verification
The block has no parameters, so the bench builds the single fixed 8-bit form. That form is small enough to sweep every accumulator value against every operation code. The sweep crosses each accumulator value with all four combinations of incoming carry and half-carry, and with a mix of fixed edge operands and random operands. This exposes every nibble-boundary carry and borrow, every signed-overflow crossing and every decimal-adjust path, including the path where only the incoming flags trigger the correction. A table of hand-worked vectors pins down the exact flag values at those crossings.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       cy_i,
  input  logic       ac_i,
  input  logic       ov_i,
  output logic [7:0] res_o,
  output logic       cy_o,
  output logic       ac_o,
  output logic       ov_o
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUBB = 4'd2;
  localparam logic [3:0] OP_INC  = 4'd3;
  localparam logic [3:0] OP_DEC  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_XOR  = 4'd7;
  localparam logic [3:0] OP_CLR  = 4'd8;
  localparam logic [3:0] OP_CPL  = 4'd9;
  localparam logic [3:0] OP_SWAP = 4'd10;
  localparam logic [3:0] OP_RL   = 4'd11;
  localparam logic [3:0] OP_RLC  = 4'd12;
  localparam logic [3:0] OP_RR   = 4'd13;
  localparam logic [3:0] OP_RRC  = 4'd14;
  localparam logic [3:0] OP_DA   = 4'd15;

  // Shared adder: subtraction adds the inverted operand and inverted borrow.
  logic       is_sub;
  logic       cin;
  logic [7:0] b_eff;
  logic [8:0] sum9;
  logic [4:0] sum_lo;
  logic [7:0] sum_b7;
  logic       c_out7, c_out3, c_in7;

  assign is_sub = (op_i == OP_SUBB);
  assign cin    = is_sub ? ~cy_i : (op_i == OP_ADDC) & cy_i;
  assign b_eff  = is_sub ? ~opnd_i : opnd_i;
  assign sum9   = {1'b0, acc_i} + {1'b0, b_eff} + {8'd0, cin};
  assign sum_lo = {1'b0, acc_i[3:0]} + {1'b0, b_eff[3:0]} + {4'd0, cin};
  assign sum_b7 = {1'b0, acc_i[6:0]} + {1'b0, b_eff[6:0]} + {7'd0, cin};
  assign c_out7 = sum9[8] ^ is_sub;
  assign c_out3 = sum_lo[4] ^ is_sub;
  assign c_in7  = sum_b7[7] ^ is_sub;

  // Decimal adjust in two correction steps.
  logic       lo_fix, hi_fix, da_c1;
  logic [8:0] da_s1, da_s2;

  assign lo_fix = (acc_i[3:0] > 4'd9) | ac_i;
  assign da_s1  = {1'b0, acc_i} + (lo_fix ? 9'h006 : 9'h000);
  assign da_c1  = cy_i | da_s1[8];
  assign hi_fix = (da_s1[7:4] > 4'd9) | da_c1;
  assign da_s2  = {1'b0, da_s1[7:0]} + (hi_fix ? 9'h060 : 9'h000);

  always_comb begin
    res_o = acc_i;
    cy_o  = cy_i;
    ac_o  = ac_i;
    ov_o  = ov_i;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_o = sum9[7:0];
        cy_o  = c_out7;
        ac_o  = c_out3;
        ov_o  = c_in7 ^ c_out7;
      end
      OP_INC:  res_o = acc_i + 8'd1;
      OP_DEC:  res_o = acc_i - 8'd1;
      OP_AND:  res_o = acc_i & opnd_i;
      OP_OR:   res_o = acc_i | opnd_i;
      OP_XOR:  res_o = acc_i ^ opnd_i;
      OP_CLR:  res_o = 8'h00;
      OP_CPL:  res_o = ~acc_i;
      OP_SWAP: res_o = {acc_i[3:0], acc_i[7:4]};
      OP_RL:   res_o = {acc_i[6:0], acc_i[7]};
      OP_RR:   res_o = {acc_i[0], acc_i[7:1]};
      OP_RLC: begin
        res_o = {acc_i[6:0], cy_i};
        cy_o  = acc_i[7];
      end
      OP_RRC: begin
        res_o = {cy_i, acc_i[7:1]};
        cy_o  = acc_i[0];
      end
      OP_DA: begin
        res_o = da_s2[7:0];
        cy_o  = da_c1 | da_s2[8];
      end
      default: res_o = acc_i;
    endcase
  end

  always_comb begin
    if (op_i inside {OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL,
                     OP_SWAP, OP_RL, OP_RR})
      p_flags_hold_r4: assert ({cy_o, ac_o, ov_o} == {cy_i, ac_i, ov_i})
        else $error("flags changed on a flag-neutral operation");
    if (op_i == OP_CLR)
      p_clear_zero_r6: assert (res_o == 8'h00) else $error("clear not zero");
    if (op_i == OP_SWAP)
      p_swap_nibbles_r7: assert (res_o[3:0] == acc_i[7:4] && res_o[7:4] == acc_i[3:0])
        else $error("swap mismatch");
    if (op_i == OP_RLC)
      p_rlc_carry_r9: assert (cy_o == acc_i[7] && res_o[0] == cy_i && ov_o == ov_i)
        else $error("rotate-left-through-carry mismatch");
    if (op_i == OP_RRC)
      p_rrc_carry_r9: assert (cy_o == acc_i[0] && res_o[7] == cy_i && ac_o == ac_i)
        else $error("rotate-right-through-carry mismatch");
    if (op_i == OP_DA && cy_i)
      p_da_keeps_carry_r10: assert (cy_o) else $error("decimal adjust cleared carry");
    if (op_i == OP_ADD)
      p_add_sum_r1: assert ({cy_o, res_o} == {1'b0, acc_i} + {1'b0, opnd_i})
        else $error("add sum mismatch");
  end

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 14;

  // {op, acc, opnd, {cy,ac,ov} in, res, {cy,ac,ov} out}
  localparam logic [33:0] VEC [NVEC] = '{
    {4'd0,  8'h7F, 8'h01, 3'b100, 8'h80, 3'b011},  // R1 carry in ignored, overflow
    {4'd1,  8'hFF, 8'h00, 3'b100, 8'h00, 3'b110},  // R2
    {4'd2,  8'h00, 8'h01, 3'b000, 8'hFF, 3'b110},  // R3 borrow
    {4'd2,  8'h80, 8'h00, 3'b100, 8'h7F, 3'b011},  // R3 overflow
    {4'd15, 8'h9A, 8'h00, 3'b000, 8'h00, 3'b100},  // R10 both fixes, carry out
    {4'd15, 8'h15, 8'h00, 3'b010, 8'h1B, 3'b010},  // R10 half-carry forces low fix
    {4'd15, 8'h00, 8'h00, 3'b100, 8'h60, 3'b100},  // R10 carry forces high fix
    {4'd12, 8'h80, 8'h00, 3'b000, 8'h00, 3'b100},  // R9
    {4'd14, 8'h01, 8'h00, 3'b100, 8'h80, 3'b100},  // R9
    {4'd10, 8'hA5, 8'h00, 3'b101, 8'h5A, 3'b101},  // R7
    {4'd11, 8'h81, 8'h00, 3'b010, 8'h03, 3'b010},  // R8
    {4'd4,  8'h00, 8'h00, 3'b111, 8'hFF, 3'b111},  // R4 wrap
    {4'd9,  8'h0F, 8'h33, 3'b000, 8'hF0, 3'b000},  // R6
    {4'd8,  8'hAA, 8'h55, 3'b011, 8'h00, 3'b011}   // R6
  };

  logic       clk = 1'b0;
  logic [3:0] op = 4'd8;
  logic [7:0] acc = 8'h00, opnd = 8'h00;
  logic       cy = 1'b0, ac = 1'b0, ov = 1'b0;
  logic [7:0] res;
  logic       cy_o, ac_o, ov_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc_alu u_dut (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .ac_i(ac), .ov_i(ov),
    .res_o(res), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
  );

  function automatic logic [10:0] model(input int o, input int a, input int b,
                                        input bit c, input bit h, input bit v);
    int r, s, lo, s7;
    bit nc, nh, nv;
    r = a; nc = c; nh = h; nv = v;
    case (o)
      0, 1: begin
        s  = a + b + ((o == 1) ? int'(c) : 0);
        lo = (a % 16) + (b % 16) + ((o == 1) ? int'(c) : 0);
        s7 = (a % 128) + (b % 128) + ((o == 1) ? int'(c) : 0);
        r = s % 256; nc = (s > 255); nh = (lo > 15); nv = (s7 > 127) ^ nc;
      end
      2: begin
        s  = a - b - int'(c);
        lo = (a % 16) - (b % 16) - int'(c);
        s7 = (a % 128) - (b % 128) - int'(c);
        r = (s + 256) % 256; nc = (s < 0); nh = (lo < 0); nv = (s7 < 0) ^ nc;
      end
      3: r = (a + 1) % 256;
      4: r = (a + 255) % 256;
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      8: r = 0;
      9: r = 255 - a;
      10: r = (a % 16) * 16 + a / 16;
      11: r = (a * 2) % 256 + a / 128;
      12: begin r = (a * 2) % 256 + int'(c); nc = (a >= 128); end
      13: r = a / 2 + (a % 2) * 128;
      14: begin r = a / 2 + int'(c) * 128; nc = (a % 2 == 1); end
      default: begin
        s = a;
        if ((s % 16) > 9 || h) s = s + 6;
        if (s > 255) nc = 1'b1;
        s = s % 256;
        if ((s / 16) > 9 || nc) s = s + 96;
        if (s > 255) nc = 1'b1;
        r = s % 256;
      end
    endcase
    return {r[7:0], nc, nh, nv};
  endfunction

  function automatic string tag(input int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5, 6, 7: return "R5";
      8, 9: return "R6";
      10: return "R7";
      11, 13: return "R8";
      12, 14: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string rq, input logic [10:0] exp);
    checks++;
    if ({res, cy_o, ac_o, ov_o} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d acc=%h opnd=%h cy=%b ac=%b ov=%b: actual res=%h flags=%b%b%b expected res=%h flags=%b",
               rq, op, acc, opnd, cy, ac, ov, res, cy_o, ac_o, ov_o, exp[10:3], exp[2:0]);
    end
  endtask

  task automatic apply(input int o, input int a, input int b, input bit c, input bit h, input bit v);
    @(negedge clk);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; cy = c; ac = h; ov = v;
    #1;
  endtask

  initial begin
    int ops [4];
    // Idle state with clear selected: output zero, flags pass through (R6)
    #1;
    check("R6", 11'b0);

    foreach (VEC[i]) begin
      apply(int'(VEC[i][33:30]), int'(VEC[i][29:22]), int'(VEC[i][21:14]),
            VEC[i][13], VEC[i][12], VEC[i][11]);
      check(tag(int'(VEC[i][33:30])), VEC[i][10:0]);
    end

    // Directed corners: R5 logic ops with flags set, R4 increment wrap, R1 ignores carry
    apply(5, 8'hF0, 8'h3C, 1, 1, 1); check("R5", {8'h30, 3'b111});
    apply(6, 8'hF0, 8'h0C, 0, 1, 0); check("R5", {8'hFC, 3'b010});
    apply(7, 8'hFF, 8'h0F, 1, 0, 0); check("R5", {8'hF0, 3'b100});
    apply(3, 8'hFF, 8'h00, 1, 0, 1); check("R4", {8'h00, 3'b101});
    apply(0, 8'h08, 8'h08, 1, 0, 0); check("R1", {8'h10, 3'b010});
    apply(13, 8'h01, 8'h00, 0, 0, 0); check("R8", {8'h80, 3'b000});

    // Sweep: all ops, all accumulator values, all carry/half-carry pairs
    ops[0] = 0; ops[1] = 255; ops[2] = 8'h99;
    for (int o = 0; o < 16; o++) begin
      ops[3] = int'($urandom_range(0, 255));
      for (int a = 0; a < 256; a++) begin
        for (int f = 0; f < 4; f++) begin
          for (int k = 0; k < 4; k++) begin
            int b;
            b = (k == 3) ? int'($urandom_range(0, 255)) : ops[k];
            apply(o, a, b, f[0], f[1], a[0]);
            check(tag(o), model(o, a, b, f[0], f[1], a[0]));
          end
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule